// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block sits on a switch's 16-bit host register bus. It gives the host a way to reach the management registers of the internal PHYs without mapping each one into the bus. Access takes two steps. First the host writes a direction bit to a control register. Then it issues one bus write to a command address. That address carries the target PHY as a one-hot select, the page and the register number. For a PHY write, the data of that bus write is what goes to the PHY. For a PHY read, the data is ignored; the bridge fetches the register and holds the value in a data register for the host to read.

On the PHY side the bridge drives a simple request/acknowledge port. A transaction stays in flight from the accepted command until the acknowledge. During that time a busy flag is visible, and any further command write is stalled with a bus wait signal. A command address that names no PHY, several PHYs, a PHY past the last one, or a page past the last one starts no transaction and sets a sticky error flag.

Top module: `phy_indirect_bridge`

## Requirements
- R1: After synchronous reset, phy_req is 0 and both the control register (address 0x8000) and the data register (address 0x8002) read as 0.
- R2: A bus write to 0x8000 stores bit 0 of the write data as the direction (1 = PHY read, 0 = PHY write). A read of 0x8000 returns the direction in bit 0, the error flag in bit 14 and the busy flag in bit 15, with all other bits 0.
- R3: A command address is 0x8000 with bit (9 + n) set to select PHY n (n = 0 to 4), the page in bits 8:5 and the register number in bits 4:0. An accepted command drives phy_sel one-hot with bit n set, phy_page and phy_reg from those fields.
- R4: With direction 0, a command drives phy_wr = 1 and forwards the command's bus write data on phy_wdata.
- R5: With direction 1, a command drives phy_wr = 0 and phy_wdata = 0 whatever the bus data was. The phy_rdata returned with phy_ack is then readable at 0x8002.
- R6: The data register keeps its value until the next PHY read completes. Write commands and rejected commands leave it unchanged.
- R7: A command address whose PHY select field (bits 14:9) has no bit set, more than one bit set, or bit 14 set starts no transaction and sets the error flag. The flag stays set until reset.
- R8: A command address with a page value above 7 starts no transaction and sets the error flag.
- R9: From the cycle after a command is accepted until phy_ack, phy_req stays high and the busy bit reads 1. phy_sel, phy_page, phy_reg, phy_wr and phy_wdata hold steady during that time.
- R10: A command write presented while busy drives bus_wait high and has no effect. It is accepted in the first cycle the bridge is not busy.
- R11: phy_req falls in the cycle after phy_ack, and each accepted command produces exactly one acknowledged PHY transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host bus write strobe |
| bus_rd | input | 1 | Host bus read strobe |
| bus_addr | input | 16 | Host bus address |
| bus_wdata | input | 16 | Host bus write data |
| bus_rdata | output | 16 | Host bus read data; 0 when no read is in progress |
| bus_wait | output | 1 | Holds off a command write while a PHY transaction is in flight |
| phy_req | output | 1 | PHY transaction request |
| phy_sel | output | 5 | One-hot PHY select |
| phy_page | output | 4 | PHY register page |
| phy_reg | output | 5 | PHY register number |
| phy_wr | output | 1 | 1 for a PHY write, 0 for a PHY read |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | PHY transaction acknowledge |
| phy_rdata | input | 16 | PHY read data, valid with phy_ack |

## Verification
The bridge is driven with write-then-read round trips through a behavioural PHY register store. This tells a correct field decode apart from a swapped or shifted PHY, page or register field. The corner targets are PHY 0 page 0 register 0 and PHY 4 page 7 register 31. Acknowledge latency varies from zero to three cycles, and back-to-back commands are issued. This separates correct busy and wait handling from a bridge that drops a stalled command, accepts it early or issues it twice. Rejected addresses cover each malformed select pattern and an oversized page, with a reset between them, so each alone must raise the error flag. The data register is read after writes and after rejected commands to show it only moves on a completed read.

// File: rtl/pib_pkg.sv
`timescale 1ns/1ps
package pib_pkg;
    parameter int DATA_W   = 16;
    parameter int ADDR_W   = 16;
    parameter int NUM_PHY  = 5;
    parameter int PAGE_W   = 4;
    parameter int REG_W    = 5;
    parameter int PAGE_MAX = 7;
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 16'h8000;
    parameter logic [ADDR_W-1:0] RDATA_ADDR = 16'h8002;

    localparam int PAGE_LSB = REG_W;
    localparam int PHY_LSB  = REG_W + PAGE_W;
    localparam int SEL_W    = ADDR_W - 1 - PHY_LSB;
    localparam int BUSY_BIT = DATA_W - 1;
    localparam int ERR_BIT  = DATA_W - 2;
    localparam int DIR_BIT  = 0;

    typedef enum logic {
        DIR_WR = 1'b0,
        DIR_RD = 1'b1
    } dir_e;

    typedef struct packed {
        logic [NUM_PHY-1:0] sel;
        logic [PAGE_W-1:0]  page;
        logic [REG_W-1:0]   regn;
        dir_e               dir;
        logic [DATA_W-1:0]  wdata;
    } phy_cmd_t;

    // True when exactly one select bit is set and it names an existing PHY.
    function automatic logic sel_is_single(input logic [SEL_W-1:0] f);
        int  cnt;
        logic beyond;
        cnt    = 0;
        beyond = 1'b0;
        for (int i = 0; i < SEL_W; i++) begin
            if (f[i]) begin
                cnt++;
                if (i >= NUM_PHY) beyond = 1'b1;
            end
        end
        return (cnt == 1) && !beyond;
    endfunction
endpackage

// File: rtl/pib_cmd_decode.sv
`timescale 1ns/1ps
module pib_cmd_decode
    import pib_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  dir_e              dir,
    output logic              hit_ctrl,
    output logic              hit_rdata,
    output logic              hit_cmd,
    output logic              cmd_ok,
    output phy_cmd_t          cmd
);
    logic [SEL_W-1:0]  sel_f;
    logic [PAGE_W-1:0] page_f;
    logic [REG_W-1:0]  reg_f;
    logic              page_ok;

    always_comb begin
        sel_f     = addr[ADDR_W-2:PHY_LSB];
        page_f    = addr[PHY_LSB-1:PAGE_LSB];
        reg_f     = addr[REG_W-1:0];
        hit_ctrl  = (addr == CTRL_ADDR);
        hit_rdata = (addr == RDATA_ADDR);
        hit_cmd   = addr[ADDR_W-1] && !hit_ctrl && !hit_rdata;
        page_ok   = (page_f <= PAGE_W'(PAGE_MAX));
        cmd_ok    = sel_is_single(sel_f) && page_ok;

        cmd.sel   = sel_f[NUM_PHY-1:0];
        cmd.page  = page_f;
        cmd.regn  = reg_f;
        cmd.dir   = dir;
        cmd.wdata = (dir == DIR_RD) ? '0 : wdata;
    end
endmodule

// File: rtl/pib_xact_engine.sv
`timescale 1ns/1ps
module pib_xact_engine
    import pib_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  phy_cmd_t          cmd_in,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_rdata,
    output logic              busy,
    output phy_cmd_t          cmd_q,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } st_e;

    st_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cmd_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) begin
                    cmd_q <= cmd_in;
                    st_q  <= ST_WAIT;
                end
                ST_WAIT: if (phy_ack) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = (st_q == ST_WAIT);
        rd_done = busy && phy_ack && (cmd_q.dir == DIR_RD);
        rd_data = phy_rdata;
    end

    // R9: request and its fields stay put until acknowledged
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !phy_ack) |=> (busy && $stable(cmd_q)));

    // R11: request ends the cycle after the acknowledge
    p_req_drop_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && phy_ack) |=> !busy);

    // R3: an issued request targets exactly one PHY
    p_sel_single_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($countones(cmd_q.sel) == 1));

    // R10: no new command is launched over one in flight
    p_no_start_busy_r10: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
endmodule

// File: rtl/pib_host_regs.sv
`timescale 1ns/1ps
module pib_host_regs
    import pib_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              ctrl_wbit,
    input  logic              err_set,
    input  logic              busy,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_en,
    input  logic              rd_ctrl,
    input  logic              rd_rdata,
    output dir_e              dir,
    output logic [DATA_W-1:0] rdata
);
    logic              err_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] ctrl_view;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir    <= DIR_WR;
            err_q  <= 1'b0;
            data_q <= '0;
        end else begin
            if (ctrl_we) dir <= dir_e'(ctrl_wbit);
            if (err_set) err_q <= 1'b1;
            if (rd_done) data_q <= rd_data;
        end
    end

    always_comb begin
        ctrl_view           = '0;
        ctrl_view[DIR_BIT]  = (dir == DIR_RD);
        ctrl_view[ERR_BIT]  = err_q;
        ctrl_view[BUSY_BIT] = busy;
        if (!rd_en)        rdata = '0;
        else if (rd_ctrl)  rdata = ctrl_view;
        else if (rd_rdata) rdata = data_q;
        else               rdata = '0;
    end

    // R7: error flag never clears outside reset
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R6: data register moves only on a completed read
    p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_done |=> $stable(data_q));

    // R2: direction changes only through a control write
    p_dir_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_we |=> $stable(dir));
endmodule

// File: rtl/phy_indirect_bridge.sv
`timescale 1ns/1ps
module phy_indirect_bridge
    import pib_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_wait,
    output logic               phy_req,
    output logic [NUM_PHY-1:0] phy_sel,
    output logic [PAGE_W-1:0]  phy_page,
    output logic [REG_W-1:0]   phy_reg,
    output logic               phy_wr,
    output logic [DATA_W-1:0]  phy_wdata,
    input  logic               phy_ack,
    input  logic [DATA_W-1:0]  phy_rdata
);
    logic              hit_ctrl, hit_rdata, hit_cmd, cmd_ok;
    logic              busy, start, err_set, rd_done;
    logic [DATA_W-1:0] rd_data;
    dir_e              dir;
    phy_cmd_t          cmd_new, cmd_q;

    pib_cmd_decode u_dec (
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .dir       (dir),
        .hit_ctrl  (hit_ctrl),
        .hit_rdata (hit_rdata),
        .hit_cmd   (hit_cmd),
        .cmd_ok    (cmd_ok),
        .cmd       (cmd_new)
    );

    always_comb begin
        bus_wait = bus_wr && hit_cmd && busy;
        start    = bus_wr && hit_cmd && !busy && cmd_ok;
        err_set  = bus_wr && hit_cmd && !busy && !cmd_ok;
    end

    pib_xact_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd_in    (cmd_new),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata),
        .busy      (busy),
        .cmd_q     (cmd_q),
        .rd_done   (rd_done),
        .rd_data   (rd_data)
    );

    pib_host_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (bus_wr && hit_ctrl),
        .ctrl_wbit (bus_wdata[DIR_BIT]),
        .err_set   (err_set),
        .busy      (busy),
        .rd_done   (rd_done),
        .rd_data   (rd_data),
        .rd_en     (bus_rd),
        .rd_ctrl   (hit_ctrl),
        .rd_rdata  (hit_rdata),
        .dir       (dir),
        .rdata     (bus_rdata)
    );

    always_comb begin
        phy_req   = busy;
        phy_sel   = cmd_q.sel;
        phy_page  = cmd_q.page;
        phy_reg   = cmd_q.regn;
        phy_wr    = (cmd_q.dir == DIR_WR);
        phy_wdata = cmd_q.wdata;
    end

    // R1: reset leaves no request pending
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !phy_req);

    // R10: wait is only ever raised over a transaction in flight
    p_wait_busy_r10: assert property (@(posedge clk) disable iff (rst)
        bus_wait |-> phy_req);

    // R7: a rejected command launches nothing
    p_bad_cmd_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit_cmd && !cmd_ok && !phy_req) |=> !phy_req);

    // R9: an accepted command raises the request next cycle
    p_start_req_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> phy_req);
endmodule

// File: tb/phy_indirect_bridge_bench.sv
`timescale 1ns/1ps
module phy_indirect_bridge_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_addr = '0, bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_wait;
    logic        phy_req, phy_wr;
    logic [4:0]  phy_sel, phy_reg;
    logic [3:0]  phy_page;
    logic [15:0] phy_wdata;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_rdata = '0;

    int n_chk = 0, n_fail = 0;
    int lat = 0, rcnt = 0, n_xact = 0, n_waits = 0;
    logic [15:0] mem [0:1279];

    // reference model state
    bit          m_dir, m_err, m_busy, m_wr;
    logic [15:0] m_data, m_wdata;
    logic [4:0]  m_sel, m_reg;
    logic [3:0]  m_page;

    always #2.5 clk = ~clk;

    phy_indirect_bridge u_phy_indirect_bridge (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_wait(bus_wait), .phy_req(phy_req), .phy_sel(phy_sel),
        .phy_page(phy_page), .phy_reg(phy_reg), .phy_wr(phy_wr),
        .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );

    function automatic logic [15:0] init_val(input int i);
        return 16'((i * 16'h0123) ^ 16'h5A5A);
    endfunction

    function automatic int idx(input int phy, input int page, input int rg);
        return phy * 256 + page * 32 + rg;
    endfunction

    function automatic logic [15:0] cmd_addr(input int phy, input int page, input int rg);
        return 16'h8000 | 16'(1 << (9 + phy)) | 16'(page << 5) | 16'(rg);
    endfunction

    function automatic bit is_cmd(input logic [15:0] a);
        return a[15] && (a != 16'h8000) && (a != 16'h8002);
    endfunction

    function automatic bit cmd_valid(input logic [15:0] a);
        int ones = 0;
        for (int b = 9; b <= 14; b++) if (a[b]) ones++;
        return (ones == 1) && !a[14] && (a[8:5] < 8);
    endfunction

    function automatic int onehot_to_num(input logic [4:0] s);
        for (int b = 0; b < 5; b++) if (s[b]) return b;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle reference model
    always @(posedge clk) begin : model
        bit was_busy;
        if (rst) begin
            m_dir = 0; m_err = 0; m_busy = 0; m_data = '0;
        end else begin
            was_busy = m_busy;
            if (m_busy && phy_ack) begin
                m_busy = 0;
                if (!m_wr) m_data = phy_rdata;
            end
            if (bus_wr) begin
                if (bus_addr == 16'h8000) m_dir = bus_wdata[0];
                else if (is_cmd(bus_addr) && !was_busy) begin
                    if (cmd_valid(bus_addr)) begin
                        m_busy  = 1;
                        m_sel   = bus_addr[13:9];
                        m_page  = bus_addr[8:5];
                        m_reg   = bus_addr[4:0];
                        m_wr    = !m_dir;
                        m_wdata = m_dir ? 16'h0 : bus_wdata;
                    end else begin
                        m_err = 1;
                    end
                end
            end
        end
    end

    // per-cycle comparison, then PHY responder
    always @(negedge clk) begin : cmp_resp
        logic [15:0] exp_rd;
        if (!rst) begin
            chk(phy_req === m_busy, "R9 request level", 32'(phy_req), 32'(m_busy));
            if (m_busy) begin
                chk(phy_sel === m_sel, "R3 phy_sel", 32'(phy_sel), 32'(m_sel));
                chk(phy_page === m_page, "R3 phy_page", 32'(phy_page), 32'(m_page));
                chk(phy_reg === m_reg, "R3 phy_reg", 32'(phy_reg), 32'(m_reg));
                chk(phy_wr === m_wr, "R4 phy_wr", 32'(phy_wr), 32'(m_wr));
                chk(phy_wdata === m_wdata, "R5 phy_wdata", 32'(phy_wdata), 32'(m_wdata));
            end
            chk(bus_wait === (m_busy && bus_wr && is_cmd(bus_addr)), "R10 bus_wait",
                32'(bus_wait), 32'(m_busy && bus_wr && is_cmd(bus_addr)));
            if (bus_rd) begin
                if (bus_addr == 16'h8000) exp_rd = {m_busy, m_err, 13'h0, m_dir};
                else if (bus_addr == 16'h8002) exp_rd = m_data;
                else exp_rd = 16'h0;
                chk(bus_rdata === exp_rd, "R2 bus_rdata", 32'(bus_rdata), 32'(exp_rd));
            end
        end
        if (rst || phy_ack) begin
            phy_ack = 1'b0;
            rcnt    = 0;
        end else if (phy_req) begin
            if (rcnt >= lat) begin
                phy_ack = 1'b1;
                rcnt    = 0;
                n_xact++;
                if (phy_wr) mem[idx(onehot_to_num(phy_sel), int'(phy_page), int'(phy_reg))] = phy_wdata;
                else phy_rdata = mem[idx(onehot_to_num(phy_sel), int'(phy_page), int'(phy_reg))];
            end else begin
                rcnt++;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk); #1 rst = 1'b1;
        repeat (2) @(negedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic bw(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        while (bus_wait) begin
            n_waits++;
            @(negedge clk); #2;
        end
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [15:0] a, output logic [15:0] v);
        @(negedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (phy_req);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        int x0;
        for (int i = 0; i < 1280; i++) mem[i] = init_val(i);
        do_reset();

        // R1 reset state
        br(16'h8000, v); chk(v == 16'h0, "R1 ctrl after reset", 32'(v), 32'h0);
        br(16'h8002, v); chk(v == 16'h0, "R1 data after reset", 32'(v), 32'h0);
        chk(phy_req == 1'b0, "R1 no request", 32'(phy_req), 32'h0);

        // R2 direction register
        bw(16'h8000, 16'hFFFF); br(16'h8000, v); chk(v == 16'h0001, "R2 dir read", 32'(v), 32'h1);
        bw(16'h8000, 16'h0000); br(16'h8000, v); chk(v == 16'h0000, "R2 dir write", 32'(v), 32'h0);

        // R4 write then R5 read back
        lat = 2;
        bw(cmd_addr(2, 3, 17), 16'h1234); wait_idle();
        chk(mem[idx(2, 3, 17)] == 16'h1234, "R4 PHY store", 32'(mem[idx(2, 3, 17)]), 32'h1234);
        bw(16'h8000, 16'h0001);
        bw(cmd_addr(2, 3, 17), 16'hFFFF); wait_idle();
        br(16'h8002, v); chk(v == 16'h1234, "R5 read back", 32'(v), 32'h1234);

        // R5 lowest corner, zero latency
        lat = 0;
        bw(cmd_addr(0, 0, 0), 16'hBEEF); wait_idle();
        br(16'h8002, v); chk(v == init_val(0), "R5 phy0 page0 reg0", 32'(v), 32'(init_val(0)));

        // R6 write command leaves data register alone
        bw(16'h8000, 16'h0000);
        bw(cmd_addr(1, 1, 1), 16'h7777); wait_idle();
        br(16'h8002, v); chk(v == init_val(0), "R6 hold over write", 32'(v), 32'(init_val(0)));

        // R3 highest corner
        lat = 1;
        bw(cmd_addr(4, 7, 31), 16'hA5A5); wait_idle();
        bw(16'h8000, 16'h0001);
        bw(cmd_addr(4, 7, 31), 16'h0000); wait_idle();
        br(16'h8002, v); chk(v == 16'hA5A5, "R3 phy4 page7 reg31", 32'(v), 32'hA5A5);

        // R9 busy visible during transaction
        lat = 3;
        bw(cmd_addr(3, 2, 5), 16'h0);
        br(16'h8000, v); chk(v == 16'h8001, "R9 busy set", 32'(v), 32'h8001);
        wait_idle();
        br(16'h8000, v); chk(v == 16'h0001, "R9 busy clear", 32'(v), 32'h1);

        // R10 and R11 back-to-back commands
        x0 = n_xact; n_waits = 0;
        bw(cmd_addr(1, 0, 2), 16'h0);
        bw(cmd_addr(1, 0, 3), 16'h0);
        chk(n_waits > 0, "R10 second command stalled", 32'(n_waits), 32'h1);
        wait_idle();
        chk(n_xact - x0 == 2, "R11 one transaction each", 32'(n_xact - x0), 32'h2);
        br(16'h8002, v); chk(v == init_val(idx(1, 0, 3)), "R10 stalled command done", 32'(v), 32'(init_val(idx(1, 0, 3))));

        // R7 no PHY selected; data register unchanged
        x0 = n_xact;
        bw(16'h8001, 16'h0); repeat (3) @(negedge clk);
        br(16'h8000, v); chk(v == 16'h4001, "R7 empty select", 32'(v), 32'h4001);
        br(16'h8002, v); chk(v == init_val(idx(1, 0, 3)), "R6 hold over rejected", 32'(v), 32'(init_val(idx(1, 0, 3))));
        chk(n_xact == x0, "R7 no transaction", 32'(n_xact), 32'(x0));
        bw(cmd_addr(0, 1, 1), 16'h0); wait_idle();
        br(16'h8000, v); chk(v == 16'h4001, "R7 sticky", 32'(v), 32'h4001);

        // R7 two PHYs selected
        do_reset();
        bw(16'h8000 | 16'h0600 | 16'h0003, 16'h0); repeat (3) @(negedge clk);
        br(16'h8000, v); chk(v == 16'h4000, "R7 two selects", 32'(v), 32'h4000);

        // R7 select past last PHY
        do_reset();
        bw(16'hC000 | 16'h0001, 16'h0); repeat (3) @(negedge clk);
        br(16'h8000, v); chk(v == 16'h4000, "R7 bit 14 select", 32'(v), 32'h4000);

        // R8 page above 7
        do_reset();
        x0 = n_xact;
        bw(16'h8000 | 16'h0200 | 16'h0100 | 16'h0003, 16'h0); repeat (3) @(negedge clk);
        br(16'h8000, v); chk(v == 16'h4000, "R8 page 8 rejected", 32'(v), 32'h4000);
        chk(n_xact == x0, "R8 no transaction", 32'(n_xact), 32'(x0));

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule